// File: doc/BRIEF.md
# Dual-Channel Converter Configuration Register File

This block is the control register file behind the serial configuration port of a two-channel data converter. An external host frames each access with an active-low chip select. It shifts in a 16-bit instruction and then one data byte. On a read, the block returns a byte on the serial output. The register map holds chip-wide (global) settings and settings kept separately for each channel (local). A channel-select register decides which channels a local write reaches.

Control registers are double-buffered. Every serial write lands in a master copy. The rest of the chip sees only the active (slave) copy. A write of 1 to bit 0 of the commit register at 0x0FF copies all master copies into the slave copies in a single cycle. The slave values leave the block through registered outputs: per-channel power and test-pattern controls, plus chip-wide power-pin behaviour, clock divide and duty-cycle stabilizer enable.

The port configuration byte selects bit order and soft reset. Its two nibbles mirror each other, so the byte decodes the same whichever bit order the host currently uses. The serial pins are sampled in the system clock domain.

Top module: `cfg_regfile`

## Requirements
- R1: After reset, address 0x00 reads 0x18, 0x05 reads 0x03 and 0x09 reads 0x01. Addresses 0x08, 0x0B and 0x0D read 0x00. All power and test outputs are 0, clk_div is 0 and dcs_en is 1.
- R2: A frame is CS_n low, then 24 bits taken on rising SCLK. The 16-bit instruction is sent first: bit 15 = 1 for a read, bits 14:13 are ignored, and bits 12:0 are the address. The 8 data bits follow. Read data appears on sdo and advances after each falling SCLK. A frame in which CS_n rises before the 24th rising edge writes nothing.
- R3: Address 0x01 reads the chip identifier 0x12. Address 0x02 reads the speed code in bits 5:4 (default code 2'b10, so 0x20). Writes to either address change nothing.
- R4: Writes to 0x08, 0x09, 0x0B and 0x0D update only the master copy, and reads return the master copy. The outputs keep their value until a commit.
- R5: A write to 0x0FF with bit 0 set copies every master copy into its slave copy. A write with bit 0 clear copies nothing. Address 0x0FF always reads 0x00.
- R6: Bits 1:0 of 0x05 select channels 0 and 1. The local fields (0x08 bits 1:0, and 0x0D) are written only in the selected channels. Global fields are written whatever the selection.
- R7: A read of a local register returns the copy of the lowest-numbered selected channel. When no channel is selected, it returns the highest-numbered channel's copy.
- R8: For each channel, power code 01 drives pd_full, code 10 drives pd_stby, and codes 00 and 11 drive neither. Bit 5 of 0x08 is global and drives pin_stby.
- R9: Bits 2:0 of 0x0B drive clk_div, where code n means divide by n+1. dcs_en is bit 0 of 0x09 OR'ed with (clk_div != 0).
- R10: In 0x0D, bits 2:0 are the channel's test pattern code on test_mode[3c+2:3c]. Bit 4 drives pn9_rst[c] and bit 5 drives pn23_rst[c].
- R11: Writing 0x00 with bit 6 or bit 1 set selects LSB-first order. Writing 0x00 with both bits clear selects MSB-first order. In LSB-first order, the instruction arrives address bit 0 first and read/write bit last, and data bytes are sent and received bit 0 first. 0x00 reads the setting back in bits 6 and 1 (0x5A when set).
- R12: Writing 0x00 with bit 5 or bit 2 set returns every master copy, slave copy, channel select and bit order to its reset value. The soft-reset bit then reads back 0.
- R13: An address outside the map reads 0x00, and a write to it changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data out |
| lsb_first | output | 1 | Current serial bit order (1 = LSB first) |
| pd_full | output | NUM_CH | Per-channel full power-down |
| pd_stby | output | NUM_CH | Per-channel standby |
| pin_stby | output | 1 | External power pin selects standby instead of power-down |
| clk_div | output | 3 | Clock divide code (divide by code+1) |
| dcs_en | output | 1 | Duty-cycle stabilizer enable |
| test_mode | output | 3*NUM_CH | Per-channel test pattern code |
| pn9_rst | output | NUM_CH | Per-channel short-sequence generator reset |
| pn23_rst | output | NUM_CH | Per-channel long-sequence generator reset |

## Verification
The assertions assume that SCLK and CS_n are slow against clk, with each level held for several clk cycles, so that every serial edge gives exactly one synchronized edge pulse. They also assume that CS_n stays low until the 24th rising edge has been absorbed, so a write strobe always comes with a complete frame. The bench holds every SCLK half period for six clk cycles. It changes SDI only while SCLK is low, and raises CS_n a full half period after the last rising edge, except in the one deliberately shortened frame.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int ADDR_W = 13;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_PORT   = 13'h000;
  localparam logic [ADDR_W-1:0] A_ID     = 13'h001;
  localparam logic [ADDR_W-1:0] A_GRADE  = 13'h002;
  localparam logic [ADDR_W-1:0] A_CHSEL  = 13'h005;
  localparam logic [ADDR_W-1:0] A_PWR    = 13'h008;
  localparam logic [ADDR_W-1:0] A_CLKCTL = 13'h009;
  localparam logic [ADDR_W-1:0] A_DIV    = 13'h00B;
  localparam logic [ADDR_W-1:0] A_TEST   = 13'h00D;
  localparam logic [ADDR_W-1:0] A_COMMIT = 13'h0FF;

  // per-channel control fields
  typedef struct packed {
    logic [1:0] pwr;
    logic       pn23_rst;
    logic       pn9_rst;
    logic [2:0] tmode;
  } chan_cfg_t;

  // chip-wide control fields
  typedef struct packed {
    logic       pin_stby;
    logic       dcs;
    logic [2:0] div;
  } glob_cfg_t;

  localparam chan_cfg_t CHAN_DEF = '0;
  localparam glob_cfg_t GLOB_DEF = '{pin_stby: 1'b0, dcs: 1'b1, div: 3'd0};

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction
endpackage

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo
);
  localparam int INSTR_W = 16;
  localparam int FRAME_W = INSTR_W + BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_INSTR = CNT_W'(INSTR_W);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_s, cs_s, sdi_s;
  logic                   sclk_d;
  logic                   sclk_now, cs_now, sdi_now;
  logic                   rise, fall;
  logic [INSTR_W-1:0]     sh, sh_next, instr;
  logic [BYTE_W-1:0]      dbyte;
  logic [CNT_W-1:0]       cnt;
  logic                   is_read, load_tx;
  logic [BYTE_W-1:0]      tx;

  assign sclk_now = sclk_s[SYNC_STAGES-1];
  assign cs_now   = cs_s[SYNC_STAGES-1];
  assign sdi_now  = sdi_s[SYNC_STAGES-1];
  assign rise     = sclk_now & ~sclk_d & ~cs_now;
  assign fall     = ~sclk_now & sclk_d & ~cs_now;

  always_comb begin
    sh_next = {sh[INSTR_W-2:0], sdi_now};
    instr   = lsb_first ? rev16(sh_next) : sh_next;
    dbyte   = lsb_first ? rev8(sh_next[BYTE_W-1:0]) : sh_next[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_s  <= '0;
      cs_s    <= '1;
      sdi_s   <= '0;
      sclk_d  <= 1'b0;
      sh      <= '0;
      cnt     <= '0;
      is_read <= 1'b0;
      load_tx <= 1'b0;
      tx      <= '0;
      addr    <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      sclk_s  <= {sclk_s[SYNC_STAGES-2:0], sclk};
      cs_s    <= {cs_s[SYNC_STAGES-2:0], cs_n};
      sdi_s   <= {sdi_s[SYNC_STAGES-2:0], sdi};
      sclk_d  <= sclk_now;
      wr_stb  <= 1'b0;
      load_tx <= 1'b0;
      if (cs_now) begin
        cnt <= '0;
        tx  <= '0;
      end else begin
        if (rise && cnt < CNT_FRAME) begin
          sh  <= sh_next;
          cnt <= cnt + 1'b1;
          if (cnt == CNT_INSTR - 1'b1) begin
            is_read <= instr[INSTR_W-1];
            addr    <= instr[ADDR_W-1:0];
            load_tx <= instr[INSTR_W-1];
          end
          if (cnt == CNT_FRAME - 1'b1) begin
            wr_data <= dbyte;
            wr_stb  <= ~is_read;
          end
        end
        if (load_tx)
          tx <= lsb_first ? rev8(rd_data) : rd_data;
        else if (fall && cnt > CNT_INSTR && cnt < CNT_FRAME)
          tx <= {tx[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = tx[BYTE_W-1];

  // R2: a write strobe only follows a complete frame of a write instruction
  assert_wr_full_frame_R2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (cnt == CNT_FRAME && !is_read));
  // R2: read data is only loaded for read instructions
  assert_tx_load_read_R2: assert property (@(posedge clk) disable iff (rst)
    load_tx |-> is_read);
endmodule

// File: rtl/cfg_glob_regs.sv
module cfg_glob_regs
  import cfg_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              lsb_first,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              srst,
  output logic              commit,
  output glob_cfg_t         glob_m,
  output glob_cfg_t         glob_s
);
  assign srst   = wr_stb && addr == A_PORT && (wr_data[5] || wr_data[2]);
  assign commit = wr_stb && addr == A_COMMIT && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      lsb_first <= 1'b0;
      chan_sel  <= '1;
      glob_m    <= GLOB_DEF;
      glob_s    <= GLOB_DEF;
    end else begin
      if (wr_stb) begin
        case (addr)
          A_PORT:   lsb_first       <= wr_data[6] | wr_data[1];
          A_CHSEL:  chan_sel        <= wr_data[NUM_CH-1:0];
          A_PWR:    glob_m.pin_stby <= wr_data[5];
          A_CLKCTL: glob_m.dcs      <= wr_data[0];
          A_DIV:    glob_m.div      <= wr_data[2:0];
          default: ;
        endcase
      end
      if (commit) glob_s <= glob_m;
    end
  end

  // R4: the active global copy moves only on commit or soft reset
  assert_glob_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!commit && !srst) |=> $stable(glob_s));
  // R5: commit copies master into slave
  assert_glob_copy_R5: assert property (@(posedge clk) disable iff (rst)
    commit |=> glob_s == $past(glob_m));
  // R12: soft reset restores defaults
  assert_srst_default_R12: assert property (@(posedge clk) disable iff (rst)
    srst |=> (glob_m == GLOB_DEF && glob_s == GLOB_DEF && chan_sel == '1 && !lsb_first));
endmodule

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              commit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output chan_cfg_t         master,
  output chan_cfg_t         slave
);
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      master <= CHAN_DEF;
      slave  <= CHAN_DEF;
    end else begin
      if (wr_en) begin
        case (addr)
          A_PWR:  master.pwr <= wr_data[1:0];
          A_TEST: begin
            master.tmode    <= wr_data[2:0];
            master.pn9_rst  <= wr_data[4];
            master.pn23_rst <= wr_data[5];
          end
          default: ;
        endcase
      end
      if (commit) slave <= master;
    end
  end

  // R6: an unselected channel keeps its master copy
  assert_chan_unselected_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !srst) |=> $stable(master));
  // R5: commit copies this channel's master into its slave
  assert_chan_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (commit && !srst) |=> slave == $past(master));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter int          NUM_CH      = 2,
  parameter logic [7:0]  CHIP_ID     = 8'h12,
  parameter logic [1:0]  SPEED_CODE  = 2'b10,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                sdi,
  output logic                sdo,
  output logic                lsb_first,
  output logic [NUM_CH-1:0]   pd_full,
  output logic [NUM_CH-1:0]   pd_stby,
  output logic                pin_stby,
  output logic [2:0]          clk_div,
  output logic                dcs_en,
  output logic [3*NUM_CH-1:0] test_mode,
  output logic [NUM_CH-1:0]   pn9_rst,
  output logic [NUM_CH-1:0]   pn23_rst
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-1:0] addr;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [NUM_CH-1:0] chan_sel;
  logic              srst, commit;
  glob_cfg_t         glob_m, glob_s;
  chan_cfg_t         ch_m [NUM_CH];
  chan_cfg_t         ch_s [NUM_CH];
  logic [CH_W-1:0]   rd_ch;
  chan_cfg_t         rd_loc;

  cfg_spi_slave #(.SYNC_STAGES(SYNC_STAGES)) u_spi (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .lsb_first(lsb_first), .rd_data(rd_data), .addr(addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .sdo(sdo)
  );

  cfg_glob_regs #(.NUM_CH(NUM_CH)) u_glob (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .wr_data(wr_data),
    .lsb_first(lsb_first), .chan_sel(chan_sel), .srst(srst), .commit(commit),
    .glob_m(glob_m), .glob_s(glob_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    cfg_chan_bank u_bank (
      .clk(clk), .rst(rst), .srst(srst), .commit(commit),
      .wr_en(wr_stb && chan_sel[c]), .addr(addr), .wr_data(wr_data),
      .master(ch_m[c]), .slave(ch_s[c])
    );
  end

  // local readback source: lowest selected channel, else the last one
  always_comb begin
    rd_ch = CH_W'(NUM_CH - 1);
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (chan_sel[c]) rd_ch = CH_W'(c);
    rd_loc = ch_m[rd_ch];
  end

  always_comb begin
    case (addr)
      A_PORT:   rd_data = {1'b0, lsb_first, 1'b0, 1'b1, 1'b1, 1'b0, lsb_first, 1'b0};
      A_ID:     rd_data = CHIP_ID;
      A_GRADE:  rd_data = {2'b00, SPEED_CODE, 4'b0000};
      A_CHSEL:  rd_data = BYTE_W'(chan_sel);
      A_PWR:    rd_data = {2'b00, glob_m.pin_stby, 3'b000, rd_loc.pwr};
      A_CLKCTL: rd_data = {7'b0, glob_m.dcs};
      A_DIV:    rd_data = {5'b0, glob_m.div};
      A_TEST:   rd_data = {2'b00, rd_loc.pn23_rst, rd_loc.pn9_rst, 1'b0, rd_loc.tmode};
      default:  rd_data = '0;
    endcase
  end

  // registered outputs from the active copies
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_full   <= '0;
      pd_stby   <= '0;
      pin_stby  <= GLOB_DEF.pin_stby;
      clk_div   <= GLOB_DEF.div;
      dcs_en    <= GLOB_DEF.dcs;
      test_mode <= '0;
      pn9_rst   <= '0;
      pn23_rst  <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        pd_full[c]        <= ch_s[c].pwr == 2'b01;
        pd_stby[c]        <= ch_s[c].pwr == 2'b10;
        test_mode[3*c+:3] <= ch_s[c].tmode;
        pn9_rst[c]        <= ch_s[c].pn9_rst;
        pn23_rst[c]       <= ch_s[c].pn23_rst;
      end
      pin_stby <= glob_s.pin_stby;
      clk_div  <= glob_s.div;
      dcs_en   <= glob_s.dcs | (|glob_s.div);
    end
  end

  // R9: a non-unity divide always has the stabilizer on
  assert_dcs_forced_R9: assert property (@(posedge clk) disable iff (rst)
    (clk_div != 3'd0) |-> dcs_en);
  // R8: a channel is never in full power-down and standby at once
  assert_pwr_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    (pd_full & pd_stby) == '0);
endmodule

// File: tb/test_cfg_regfile.sv
module test_cfg_regfile;
  localparam int NCH = 2;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, lsb_first, pin_stby, dcs_en;
  logic [NCH-1:0] pd_full, pd_stby, pn9_rst, pn23_rst;
  logic [2:0] clk_div;
  logic [3*NCH-1:0] test_mode;

  int checks = 0, errors = 0;
  bit lsb_mode = 1'b0;
  bit done = 1'b0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  cfg_regfile i_cfg_regfile (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .lsb_first(lsb_first), .pd_full(pd_full), .pd_stby(pd_stby),
    .pin_stby(pin_stby), .clk_div(clk_div), .dcs_en(dcs_en),
    .test_mode(test_mode), .pn9_rst(pn9_rst), .pn23_rst(pn23_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input bit rd, input logic [1:0] bc, input logic [12:0] a,
                       input logic [7:0] wd, input int nbits, output logic [7:0] got);
    logic [15:0] ins;
    ins = {rd, bc, a};
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) sdi = lsb_mode ? ins[i] : ins[15-i];
      else        sdi = lsb_mode ? wd[i-16] : wd[23-i];
      half();
      if (i >= 16) begin
        if (lsb_mode) got[i-16] = sdo;
        else          got[23-i] = sdo;
      end
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    half();
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    frame(1'b0, 2'b00, a, d, 24, dummy);
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    frame(1'b1, 2'b00, a, 8'h00, 24, d);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int em [NCH];
    int es [NCH];
    int pin;
    int exp_rd;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state at the ports and through reads
    chk("R1 lsb_first", lsb_first, 0);
    chk("R1 pd_full", pd_full, 0);
    chk("R1 pd_stby", pd_stby, 0);
    chk("R1 pin_stby", pin_stby, 0);
    chk("R1 clk_div", clk_div, 0);
    chk("R1 dcs_en", dcs_en, 1);
    chk("R1 test_mode", test_mode, 0);
    chk("R1 pn resets", {pn9_rst, pn23_rst}, 0);
    rd(13'h000, rv); chk("R1 read 0x00", rv, 8'h18);
    rd(13'h005, rv); chk("R1 read 0x05", rv, 8'h03);
    rd(13'h009, rv); chk("R1 read 0x09", rv, 8'h01);
    rd(13'h008, rv); chk("R1 read 0x08", rv, 8'h00);
    rd(13'h00B, rv); chk("R1 read 0x0B", rv, 8'h00);
    rd(13'h00D, rv); chk("R1 read 0x0D", rv, 8'h00);

    // R3 read-only identity
    rd(13'h001, rv); chk("R3 chip id", rv, 8'h12);
    rd(13'h002, rv); chk("R3 speed grade", rv, 8'h20);
    wr(13'h001, 8'h55);
    wr(13'h002, 8'hFF);
    rd(13'h001, rv); chk("R3 id after write", rv, 8'h12);
    rd(13'h002, rv); chk("R3 grade after write", rv, 8'h20);

    // R4 / R5 master, slave and commit
    wr(13'h00B, 8'h03);
    chk("R4 clk_div before commit", clk_div, 0);
    rd(13'h00B, rv); chk("R4 master readback", rv, 8'h03);
    wr(13'h0FF, 8'h01);
    chk("R5 clk_div after commit", clk_div, 3);
    rd(13'h0FF, rv); chk("R5 commit reads zero", rv, 8'h00);
    wr(13'h00B, 8'h06);
    wr(13'h0FF, 8'hFE);
    chk("R5 commit bit0 clear", clk_div, 3);

    // R9 sweep of divide and stabilizer
    for (int d = 0; d < 8; d++) begin
      for (int s = 0; s < 2; s++) begin
        wr(13'h009, 8'(s));
        wr(13'h00B, 8'(d));
        wr(13'h0FF, 8'h01);
        chk("R9 clk_div", clk_div, d);
        chk("R9 dcs_en", dcs_en, (s != 0 || d != 0) ? 1 : 0);
        rd(13'h009, rv); chk("R9 raw stabilizer bit", rv, s);
      end
    end
    wr(13'h009, 8'h01);
    wr(13'h00B, 8'h00);
    wr(13'h0FF, 8'h01);

    // R6 / R7 / R8 channel selection and power decode
    for (int c = 0; c < NCH; c++) begin em[c] = 0; es[c] = 0; end
    for (int idx = 1; idx < 4; idx++) begin
      for (int m = 0; m < 4; m++) begin
        pin = m & 1;
        wr(13'h005, 8'(idx));
        wr(13'h008, 8'((pin << 5) | m));
        for (int c = 0; c < NCH; c++) if (idx[c]) em[c] = m;
        exp_rd = idx[0] ? em[0] : em[1];
        rd(13'h008, rv); chk("R7 local readback", rv, (pin << 5) | exp_rd);
        chk("R4 pd_full before commit", pd_full, {es[1] == 1, es[0] == 1});
        wr(13'h0FF, 8'h01);
        for (int c = 0; c < NCH; c++) es[c] = em[c];
        chk("R6 R8 pd_full", pd_full, {es[1] == 1, es[0] == 1});
        chk("R6 R8 pd_stby", pd_stby, {es[1] == 2, es[0] == 2});
        chk("R8 pin_stby", pin_stby, pin);
      end
    end
    wr(13'h005, 8'h00);
    wr(13'h008, 8'h21);
    wr(13'h0FF, 8'h01);
    chk("R6 no channel selected pd_full", pd_full, {es[1] == 1, es[0] == 1});
    chk("R6 global bit still written", pin_stby, 1);
    rd(13'h008, rv); chk("R7 none selected reads last channel", rv, 8'h20 | em[1]);

    // R10 test mode fields, channel 0 only
    wr(13'h005, 8'h01);
    for (int t = 0; t < 8; t++) begin
      wr(13'h00D, 8'(((t & 1) << 5) | (((t >> 1) & 1) << 4) | t));
      wr(13'h0FF, 8'h01);
      chk("R10 test_mode ch0", test_mode[2:0], t);
      chk("R10 test_mode ch1 untouched", test_mode[5:3], 0);
      chk("R10 pn23_rst ch0", pn23_rst[0], t & 1);
      chk("R10 pn9_rst ch0", pn9_rst[0], (t >> 1) & 1);
    end
    wr(13'h005, 8'h02);
    wr(13'h00D, 8'h35);
    wr(13'h0FF, 8'h01);
    chk("R10 test_mode ch1", test_mode[5:3], 5);
    chk("R10 pn resets ch1", {pn23_rst[1], pn9_rst[1]}, 3);
    rd(13'h00D, rv); chk("R7 channel 1 readback", rv, 8'h35);

    // R13 unmapped addresses
    wr(13'h00B, 8'h02);
    wr(13'h0FF, 8'h01);
    wr(13'h00B, 8'h04);
    wr(13'h1FFF, 8'hFF);
    chk("R13 alias of commit ignored", clk_div, 2);
    wr(13'h003, 8'hFF);
    wr(13'h00A, 8'hFF);
    wr(13'h100, 8'hFF);
    rd(13'h003, rv); chk("R13 read 0x003", rv, 0);
    rd(13'h00A, rv); chk("R13 read 0x00A", rv, 0);
    rd(13'h100, rv); chk("R13 read 0x100", rv, 0);
    rd(13'h1FFF, rv); chk("R13 read 0x1FFF", rv, 0);
    rd(13'h00B, rv); chk("R13 master untouched", rv, 4);

    // R2 ignored byte-count bits and aborted frame
    frame(1'b0, 2'b11, 13'h00B, 8'h02, 24, rv);
    frame(1'b1, 2'b10, 13'h00B, 8'h00, 24, rv);
    chk("R2 byte-count bits ignored", rv, 2);
    frame(1'b0, 2'b00, 13'h00B, 8'h07, 20, rv);
    rd(13'h00B, rv); chk("R2 short frame writes nothing", rv, 2);

    // R11 bit order and mirrored configuration byte
    wr(13'h000, 8'h58);
    chk("R11 lsb via bit6", lsb_first, 1);
    lsb_mode = 1'b1;
    rd(13'h000, rv); chk("R11 mirrored readback", rv, 8'h5A);
    rd(13'h001, rv); chk("R11 id in lsb order", rv, 8'h12);
    wr(13'h00B, 8'h06);
    rd(13'h00B, rv); chk("R11 write in lsb order", rv, 8'h06);
    wr(13'h000, 8'h18);
    lsb_mode = 1'b0;
    chk("R11 back to msb", lsb_first, 0);
    rd(13'h000, rv); chk("R11 msb readback", rv, 8'h18);
    wr(13'h000, 8'h1A);
    chk("R11 lsb via bit1", lsb_first, 1);
    lsb_mode = 1'b1;
    rd(13'h000, rv); chk("R11 readback after bit1", rv, 8'h5A);

    // R12 soft reset through bit2 while in lsb order
    wr(13'h0FF, 8'h01);
    wr(13'h000, 8'h5E);
    lsb_mode = 1'b0;
    chk("R12 lsb cleared", lsb_first, 0);
    chk("R12 clk_div default", clk_div, 0);
    chk("R12 test_mode default", test_mode, 0);
    rd(13'h00B, rv); chk("R12 master default", rv, 0);
    rd(13'h000, rv); chk("R12 soft reset self clears", rv, 8'h18);

    // R12 soft reset through bit5
    wr(13'h00B, 8'h05);
    wr(13'h005, 8'h01);
    wr(13'h008, 8'h01);
    wr(13'h0FF, 8'h01);
    chk("R12 setup pd_full", pd_full, 1);
    wr(13'h000, 8'h38);
    chk("R12 pd_full default", pd_full, 0);
    chk("R12 dcs_en default", dcs_en, 1);
    chk("R12 clk_div default bit5", clk_div, 0);
    rd(13'h005, rv); chk("R12 channel select default", rv, 8'h03);
    rd(13'h008, rv); chk("R12 local master default", rv, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule